// File: doc/BRIEF.md
# Time-Sliced Linked-List DMA Walker

This block follows a chain of packets stored in a 24-bit byte-addressed memory and sends the payload words of each packet to one device port. A packet starts with a 32-bit header. The upper byte of the header holds the number of payload words. The lower 24 bits hold the address of the next header. The payload words sit directly after the header, one word every 4 bytes. A next-address value with its top bit (bit 23) set marks the end of the chain. The walker then raises a one-cycle done pulse and goes idle.

A chain may loop back on itself, so the walker limits how long it runs in one go. Every memory access adds one tick to a running burst total. At each packet boundary the walker checks the device request and the budget before it starts the next packet. When the total has reached the budget, the walker stops for a fixed number of cycles. During that pause it neither reads memory nor drives the device, and it reports the pause on a status output. It then resumes at the saved address with a fresh budget. If the request is low at a boundary, the walker waits with the transfer still pending and continues once the request returns.

Top module: `ll_dma_walker`

## Requirements
- R1: A header word is decoded with bits 31:24 as the payload word count and bits 23:0 as the next header address. The walker then moves to the next address.
- R2: Payload words are read from header address + 4 upwards in steps of 4 bytes, with 24-bit wrap-around. They are sent to the device in memory order.
- R3: A header with a count of zero produces no device write, and the walker goes straight to the next address.
- R4: When the next-address field has bit 23 set, the walker finishes. It pulses `done` for one cycle, drops `busy`, and `cur_addr` shows that final next-address value.
- R5: Every memory read (header or payload) costs one tick of the burst total. A new packet starts only if the total is below `BUDGET`. Otherwise the walker enters the halted state.
- R6: The halted state lasts exactly `HALT_TICKS` cycles. While halted, `halted` is high and there are no memory reads and no device writes. Afterwards the walker re-reads the header at the saved address with the burst total cleared.
- R7: While `dev_req` is low at a packet boundary, the walker issues no memory reads and no device writes, keeps `busy` high, and does not pulse `done`. It continues when `dev_req` returns high.
- R8: A device write is presented with `dev_valid`. While `dev_ready` is low, `dev_data` holds steady, and no payload word is lost or repeated.
- R9: `start` is accepted only while the walker is idle. A `start` while busy or halted changes neither the address nor the transfer.
- R10: Memory reads have one cycle of latency. `mem_rd` is never high for two cycles in a row, so at most one read is in flight.
- R11: After reset, `busy`, `halted`, `done`, `mem_rd` and `dev_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk at `start_addr` (accepted when idle) |
| start_addr | input | 24 | Byte address of the first header |
| dev_req | input | 1 | Device request; gates each new packet |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory byte address for the read |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| dev_valid | output | 1 | Payload word offered to the device |
| dev_data | output | 32 | Payload word |
| dev_ready | input | 1 | Device accepts the offered word |
| busy | output | 1 | A walk is in progress (including waits and halts) |
| halted | output | 1 | Enforced pause after the budget ran out |
| done | output | 1 | One-cycle pulse when the end marker is reached |
| cur_addr | output | 24 | Saved header address; the end value after completion |

## Verification
The embedded assertions check on every cycle that device data holds during back-pressure and that reads never come back to back. They also check that a halt issues no traffic and lasts as long as the timer says, that done only appears with busy low, that zero-count headers cause no writes, and that the burst total grows by one per read. Only the bench scenarios can show the rest of the function. That covers the right words reaching the device in order, including across address wrap, and the exact point at which a looping chain is cut off by the budget. It also covers resuming after a halt or a dropped request at the right address, and the final address reported on completion.

// File: rtl/ll_walk_pkg.sv
package ll_walk_pkg;

    localparam int ADDR_W  = 24;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 8;
    localparam int END_BIT = ADDR_W - 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR_RD,
        ST_HDR_WT,
        ST_PAY_RD,
        ST_PAY_WT,
        ST_PAY_TX,
        ST_ADV,
        ST_HALT
    } walk_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        addr_t            next;
    } pkt_hdr_t;

    function automatic pkt_hdr_t decode_hdr(input word_t w);
        pkt_hdr_t h;
        h.count = w[WORD_W-1 -: CNT_W];
        h.next  = w[ADDR_W-1:0];
        return h;
    endfunction

    function automatic addr_t step_word(input addr_t a);
        return a + addr_t'(4);
    endfunction

    function automatic logic is_chain_end(input addr_t a);
        return a[END_BIT];
    endfunction

endpackage

// File: rtl/ll_burst_meter.sv
module ll_burst_meter #(
    parameter int BUDGET = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic over
);
    localparam int MW = $clog2(BUDGET + 512);
    localparam logic [MW-1:0] LIMIT = MW'(BUDGET);

    logic [MW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + MW'(1);
        end
    end

    assign over = (count >= LIMIT);

    // each charged access adds exactly one tick
    assert_tick_charge_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (count == $past(count) + MW'(1)));

endmodule

// File: rtl/ll_halt_timer.sv
module ll_halt_timer #(
    parameter int HALT_TICKS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic active,
    output logic expire
);
    localparam int CW = (HALT_TICKS > 1) ? $clog2(HALT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALT_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (arm) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign expire = active && (cnt == LAST);

    // pause continues until the final count is reached
    assert_pause_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !expire && !arm) |=> active);

endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker
    import ll_walk_pkg::*;
#(
    parameter int BUDGET     = 1000,
    parameter int HALT_TICKS = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [23:0] start_addr,
    input  logic        dev_req,
    output logic        mem_rd,
    output logic [23:0] mem_addr,
    input  logic [31:0] mem_rdata,
    output logic        dev_valid,
    output logic [31:0] dev_data,
    input  logic        dev_ready,
    output logic        busy,
    output logic        halted,
    output logic        done,
    output logic [23:0] cur_addr
);
    walk_state_e       state;
    addr_t             cur_q;
    addr_t             next_q;
    addr_t             rd_ptr;
    logic [CNT_W-1:0]  remain;
    word_t             out_q;
    logic              done_q;
    pkt_hdr_t          hdr;

    logic meter_clr;
    logic meter_over;
    logic halt_arm;
    logic halt_active;
    logic halt_expire;

    assign hdr = decode_hdr(mem_rdata);

    assign meter_clr = ((state == ST_IDLE) && start)
                    || ((state == ST_HALT) && halt_expire)
                    || ((state == ST_CHECK) && !dev_req);
    assign halt_arm  = (state == ST_CHECK) && meter_over;

    ll_burst_meter #(.BUDGET(BUDGET)) u_meter (
        .clk  (clk),
        .rst  (rst),
        .clr  (meter_clr),
        .inc  (mem_rd),
        .over (meter_over)
    );

    ll_halt_timer #(.HALT_TICKS(HALT_TICKS)) u_pause (
        .clk    (clk),
        .rst    (rst),
        .arm    (halt_arm),
        .active (halt_active),
        .expire (halt_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur_q  <= '0;
            next_q <= '0;
            rd_ptr <= '0;
            remain <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_q <= start_addr;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (meter_over) begin
                        state <= ST_HALT;
                    end else if (dev_req) begin
                        state <= ST_HDR_RD;
                    end
                end
                ST_HDR_RD: state <= ST_HDR_WT;
                ST_HDR_WT: begin
                    next_q <= hdr.next;
                    remain <= hdr.count;
                    rd_ptr <= step_word(cur_q);
                    state  <= (hdr.count == '0) ? ST_ADV : ST_PAY_RD;
                end
                ST_PAY_RD: state <= ST_PAY_WT;
                ST_PAY_WT: begin
                    out_q <= mem_rdata;
                    state <= ST_PAY_TX;
                end
                ST_PAY_TX: begin
                    if (dev_ready) begin
                        rd_ptr <= step_word(rd_ptr);
                        remain <= remain - CNT_W'(1);
                        state  <= (remain == CNT_W'(1)) ? ST_ADV : ST_PAY_RD;
                    end
                end
                ST_ADV: begin
                    cur_q <= next_q;
                    if (is_chain_end(next_q)) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_CHECK;
                    end
                end
                ST_HALT: begin
                    if (halt_expire) begin
                        state <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd    = (state == ST_HDR_RD) || (state == ST_PAY_RD);
    assign mem_addr  = (state == ST_HDR_RD) ? cur_q : rd_ptr;
    assign dev_valid = (state == ST_PAY_TX);
    assign dev_data  = out_q;
    assign busy      = (state != ST_IDLE);
    assign halted    = (state == ST_HALT);
    assign done      = done_q;
    assign cur_addr  = cur_q;

    // back-pressure holds the offered word
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data)));

    // one read in flight at a time
    assert_single_read_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // completion leaves the walker idle
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // pause is silent on both sides
    assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !dev_valid));

    // controller and pause timer agree
    assert_halt_sync_R6: assert property (@(posedge clk) disable iff (rst)
        halt_active == halted);

    // zero-length packet produces no device traffic
    assert_zero_skip_R3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HDR_WT) && (mem_rdata[31:24] == 8'd0)) |=> (!dev_valid && !mem_rd));

    // start during a pause leaves the saved address alone
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (halted && start) |=> (cur_addr == $past(cur_addr)));

    // a low request at a boundary issues no traffic
    assert_req_wait_R7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_CHECK) && !dev_req && !meter_over) |=> (!mem_rd && !dev_valid && busy));

endmodule

// File: tb/sim_ll_dma_walker.sv
module sim_ll_dma_walker;
    localparam int CLK_PERIOD = 10;
    localparam int BUDGET     = 12;
    localparam int HALT_TICKS = 8;
    localparam int WATCHDOG   = 50000;

    // table entry: {start, words, sum, final address, reads}
    localparam int NVEC = 3;
    localparam logic [95:0] VECS [NVEC] = '{
        {24'h000010, 8'd3, 32'h0000_01E6, 24'h800000, 8'd5},
        {24'h000080, 8'd1, 32'h0000_00B1, 24'h8000AB, 8'd4},
        {24'hFFFFF8, 8'd3, 32'h0000_0246, 24'h800001, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        dev_req = 1'b1;
    logic        mem_rd;
    logic [23:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        dev_valid;
    logic [31:0] dev_data;
    logic        dev_ready = 1'b1;
    logic        busy;
    logic        halted;
    logic        done;
    logic [23:0] cur_addr;

    logic [31:0] mem [256];
    logic [31:0] wlog [16];
    int          wr_n, rd_n, done_n, rd_in_halt;
    logic [31:0] wsum;
    logic        clr_stats = 1'b0;
    logic        stall_mode = 1'b0;
    logic [1:0]  stall_cnt = '0;
    int          total = 0;
    int          bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ll_dma_walker #(.BUDGET(BUDGET), .HALT_TICKS(HALT_TICKS)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .dev_req(dev_req), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dev_valid(dev_valid), .dev_data(dev_data),
        .dev_ready(dev_ready), .busy(busy), .halted(halted), .done(done),
        .cur_addr(cur_addr)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    end

    always @(posedge clk) begin
        if (clr_stats) begin
            wr_n <= 0; rd_n <= 0; done_n <= 0; rd_in_halt <= 0; wsum <= '0;
        end else begin
            if (dev_valid && dev_ready) begin
                if (wr_n < 16) wlog[wr_n] <= dev_data;
                wr_n <= wr_n + 1;
                wsum <= wsum + dev_data;
            end
            if (mem_rd) rd_n <= rd_n + 1;
            if (mem_rd && halted) rd_in_halt <= rd_in_halt + 1;
            if (done) done_n <= done_n + 1;
        end
    end

    always @(negedge clk) begin
        stall_cnt <= stall_cnt + 2'd1;
        dev_ready <= stall_mode ? (stall_cnt == 2'd3) : 1'b1;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_stats();
        @(negedge clk); clr_stats = 1'b1;
        @(negedge clk); clr_stats = 1'b0;
    endtask

    task automatic kick(input logic [23:0] a);
        @(negedge clk);
        start_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done_n != 0) break;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=finish", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[4]   = {8'd2, 24'h000040}; mem[5] = 32'hA1; mem[6] = 32'hA2;
        mem[16]  = {8'd1, 24'h800000}; mem[17] = 32'hA3;
        mem[32]  = {8'd0, 24'h000090};
        mem[36]  = {8'd0, 24'h000094};
        mem[37]  = {8'd1, 24'h8000AB}; mem[38] = 32'hB1;
        mem[254] = {8'd3, 24'h800001}; mem[255] = 32'hC1;
        mem[0]   = 32'hC2; mem[1] = 32'hC3;
        mem[64]  = {8'd2, 24'h000100}; mem[65] = 32'hD1; mem[66] = 32'hD2;

        clr_stats = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clr_stats = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!busy, "R11 busy", 32'(busy), 0);
        chk(!halted, "R11 halted", 32'(halted), 0);
        chk(!done, "R11 done", 32'(done), 0);
        chk(!mem_rd && !dev_valid, "R11 mem_rd/dev_valid", {mem_rd, dev_valid}, 0);

        // table walk: R1 decode, R2 wrap, R3 zero count, R4 end, R5 ticks
        for (int v = 0; v < NVEC; v++) begin
            clear_stats();
            kick(VECS[v][95:72]);
            wait_done(400);
            chk(done_n == 1, "R4 done pulse", done_n, 1);
            chk(wr_n == int'(VECS[v][71:64]), "R1/R3 word count", wr_n, VECS[v][71:64]);
            chk(wsum == VECS[v][63:32], "R2 payload sum", wsum, VECS[v][63:32]);
            chk(cur_addr == VECS[v][31:8], "R4 final cur_addr", cur_addr, VECS[v][31:8]);
            chk(rd_n == int'(VECS[v][7:0]), "R5 read ticks", rd_n, VECS[v][7:0]);
            chk(!busy, "R4 idle after done", 32'(busy), 0);
        end

        // R2/R8 order under device back-pressure
        clear_stats();
        stall_mode = 1'b1;
        kick(24'h000010);
        wait_done(400);
        stall_mode = 1'b0;
        chk(wr_n == 3, "R8 count under stall", wr_n, 3);
        chk(wlog[0] == 32'hA1, "R8 word0", wlog[0], 32'hA1);
        chk(wlog[1] == 32'hA2, "R8 word1", wlog[1], 32'hA2);
        chk(wlog[2] == 32'hA3, "R2 word2", wlog[2], 32'hA3);

        // R7 request low holds the transfer pending
        clear_stats();
        dev_req = 1'b0;
        kick(24'h000010);
        repeat (20) @(negedge clk);
        chk(busy, "R7 busy while waiting", 32'(busy), 1);
        chk(rd_n == 0 && wr_n == 0, "R7 no traffic", rd_n + wr_n, 0);
        chk(done_n == 0, "R7 no done", done_n, 0);
        chk(cur_addr == 24'h000010, "R7 saved address", cur_addr, 24'h000010);
        dev_req = 1'b1;
        wait_done(400);
        chk(wr_n == 3 && cur_addr == 24'h800000, "R7 resumes", wr_n, 3);

        // R5/R6/R9 circular chain cut by budget
        clear_stats();
        kick(24'h000100);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        chk(halted, "R5 halt entered", 32'(halted), 1);
        chk(wr_n == 8, "R5 writes before halt", wr_n, 8);
        chk(rd_n == 12, "R5 reads before halt", rd_n, 12);
        mem[64] = {8'd0, 24'h800100};
        start_addr = 24'h000010; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int hcyc = 2;
            for (int i = 0; i < 100; i++) begin
                if (!halted) break;
                @(negedge clk);
                if (halted) hcyc++;
            end
            chk(hcyc == HALT_TICKS, "R6 halt length", hcyc, HALT_TICKS);
        end
        chk(rd_in_halt == 0, "R6 no reads while halted", rd_in_halt, 0);
        wait_done(400);
        chk(done_n == 1, "R6 resumed to completion", done_n, 1);
        chk(cur_addr == 24'h800100, "R9 start during halt ignored", cur_addr, 24'h800100);
        chk(wr_n == 8, "R6 no extra writes", wr_n, 8);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule